// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Engine

This block frees an I2C bus that a target has left stuck. A target device can keep SDA low after a master loses arbitration or aborts a transfer partway through a byte. The engine releases SDA and toggles SCL through open-drain outputs. While it toggles, it samples SDA and can finish with a STOP condition, which returns both lines to the idle state.

Software sets up the operation through a small word-addressed register port. It writes the pulse limit, the termination mode and the STOP option into a shadow configuration. It then strobes a load register to copy the shadow into the active settings, and waits for the load bit to drop before it sets the enable bit. The enable bit clears itself when the operation ends. A status bit then reports whether SDA was seen high.

Top module: `bus_clear_engine`

## Requirements
- R1: After reset, the configuration register (byte offset 0x84) reads 0x00090004. This means a pulse limit of 9 in bits 22:16, STOP generation on in bit 2, early-exit mode in bit 1 = 0, and idle in bit 0. The status register (0x88) reads 0, the load register (0x8C) reads 0, and both SCL and SDA are released.
- R2: Reads of any offset other than 0x84, 0x88 and 0x8C return 0.
- R3: Writes to the configuration register store bits 22:16, 2 and 1 in a shadow copy that reads back at once. These writes do not change how the next operation runs until a load takes place.
- R4: Writing 1 to bit 0 of the load register sets that bit. When the engine is idle, the bit reads 1 for one cycle and then drops, and the shadow becomes the active configuration. If the write arrives during an operation, the copy waits until the operation ends.
- R5: Writing the configuration register with bit 0 = 1 while idle starts an operation. Bit 0 then reads 1 until the operation finishes, and reads 0 after that. The status bit is cleared when the operation starts.
- R6: Each SCL pulse drives SCL low for HALF_CYCLES clocks and then releases it for HALF_CYCLES clocks. SDA is released during all pulses, and SDA is sampled on the last clock of each released-SCL phase.
- R7: With bit 1 = 1, the engine produces exactly as many pulses as the active limit. A limit of 0 produces one pulse.
- R8: With bit 1 = 0, the engine stops after the first pulse whose sample sees SDA high. If SDA never goes high, it stops at the pulse limit.
- R9: With bit 2 = 1, the pulses are followed by four phases of HALF_CYCLES clocks each:
  - SCL low, SDA released;
  - SCL low, SDA low;
  - SCL released, SDA low;
  - both released.
  With bit 2 = 0, the operation ends straight after the last pulse.
- R10: Status bit 0 holds the SDA level sampled in the last pulse of the operation. This is 1 when the bus was cleared and 0 when SDA was still held low.
- R11: A write of bit 0 = 1 to the configuration register during an operation does not change the operation's waveform or its length.
- R12: SDA is pulled low only while SCL has been low for at least one clock. SDA is released only while SCL has been released for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte offset for read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| sdaIn | input | 1 | Sensed SDA line level, already synchronised |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume three things about the inputs:
- sdaIn is already synchronous to clk;
- regAddr is stable whenever regWrEn is high;
- the SCL line follows sclOe with no delay and no clock stretching.

The stimulus meets these assumptions. The bench drives every input on the falling edge, derives the SCL line directly from sclOe, and models the target as holding SDA low for a set number of SCL falling edges. The pulse-count assertion is checked only while an operation runs, because software may load a smaller limit after an operation has finished.

// File: rtl/bc_pkg.sv
package bc_pkg;
  localparam int THR_W = 7;
  localparam int THR_LSB = 16;
  localparam logic [THR_W-1:0] THR_RESET = 7'd9;
  localparam logic [7:0] OFS_CFG  = 8'h84;
  localparam logic [7:0] OFS_STAT = 8'h88;
  localparam logic [7:0] OFS_LOAD = 8'h8C;

  typedef struct packed {
    logic phaseClr;
    logic pulseClr;
    logic pulseInc;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_STOPA, ST_STOPB, ST_STOPC, ST_STOPD
  } bcState_t;
endpackage

// File: rtl/bc_regs.sv
module bc_regs
  import bc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              busy,
  input  logic              termSet,
  input  logic              termSda,
  output logic              startReq,
  output logic [THR_W-1:0]  actThr,
  output logic              actMode,
  output logic              actStop
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFS_LOAD);

  logic [THR_W-1:0] shThr;
  logic shMode, shStop, loadPend, cleared;
  logic cfgWr, loadWr;

  assign cfgWr  = wrEn && (addr == A_CFG);
  assign loadWr = wrEn && (addr == A_LOAD) && wrData[0];
  assign startReq = cfgWr && wrData[0] && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shThr <= THR_RESET; shMode <= 1'b0; shStop <= 1'b1;
      actThr <= THR_RESET; actMode <= 1'b0; actStop <= 1'b1;
      loadPend <= 1'b0; cleared <= 1'b0;
    end else begin
      if (cfgWr) begin
        shThr  <= wrData[THR_LSB +: THR_W];
        shStop <= wrData[2];
        shMode <= wrData[1];
      end
      if (loadWr) begin
        loadPend <= 1'b1;
      end else if (loadPend && !busy) begin
        loadPend <= 1'b0;
        actThr <= shThr; actMode <= shMode; actStop <= shStop;
      end
      if (startReq) cleared <= 1'b0;
      else if (termSet) cleared <= termSda;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == A_CFG) begin
      rdData[THR_LSB +: THR_W] = shThr;
      rdData[2] = shStop;
      rdData[1] = shMode;
      rdData[0] = busy;
    end else if (addr == A_STAT) begin
      rdData[0] = cleared;
    end else if (addr == A_LOAD) begin
      rdData[0] = loadPend;
    end
  end

  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[DATA_W-1:THR_LSB+THR_W], wrData[THR_LSB-1:3]};

  // R4
  active_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(actThr) && $stable(actMode) && $stable(actStop)));
  // R4
  load_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadPend && !busy && !loadWr) |=> !loadPend);
  // R5
  status_cleared_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !cleared);
endmodule

// File: rtl/bc_dpath.sv
module bc_dpath
  import bc_pkg::*;
#(
  parameter int HALF_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic             busy,
  input  logic [THR_W-1:0] actThr,
  output logic             phaseDone,
  output logic             lastPulse
);
  localparam int PH_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_CYCLES - 1);

  logic [PH_W-1:0] phaseCnt;
  logic [THR_W-1:0] pulseCnt;
  logic [THR_W:0] thrEff, pulseNext;

  assign thrEff    = (actThr == '0) ? (THR_W+1)'(1) : {1'b0, actThr};
  assign pulseNext = {1'b0, pulseCnt} + (THR_W+1)'(1);
  assign phaseDone = (phaseCnt == PH_LAST);
  assign lastPulse = (pulseNext >= thrEff);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      pulseCnt <= '0;
    end else begin
      if (strb.phaseClr) phaseCnt <= '0;
      else if (!phaseDone) phaseCnt <= phaseCnt + PH_W'(1);
      if (strb.pulseClr) pulseCnt <= '0;
      else if (strb.pulseInc) pulseCnt <= pulseNext[THR_W-1:0];
    end
  end

  // R7
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ({1'b0, pulseCnt} <= thrEff));
endmodule

// File: rtl/bc_ctrl.sv
module bc_ctrl
  import bc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      phaseDone,
  input  logic      lastPulse,
  input  logic      actMode,
  input  logic      actStop,
  input  logic      sdaIn,
  output dpStrobe_t strb,
  output logic      busy,
  output logic      termSet,
  output logic      sclOe,
  output logic      sdaOe
);
  bcState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb = '0;
    termSet = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        nextState = ST_LOW;
        strb.phaseClr = 1'b1;
        strb.pulseClr = 1'b1;
      end
      ST_LOW: if (phaseDone) begin
        nextState = ST_HIGH;
        strb.phaseClr = 1'b1;
      end
      ST_HIGH: if (phaseDone) begin
        strb.phaseClr = 1'b1;
        strb.pulseInc = 1'b1;
        if (lastPulse || (!actMode && sdaIn)) begin
          termSet = 1'b1;
          nextState = actStop ? ST_STOPA : ST_IDLE;
        end else begin
          nextState = ST_LOW;
        end
      end
      ST_STOPA: if (phaseDone) begin nextState = ST_STOPB; strb.phaseClr = 1'b1; end
      ST_STOPB: if (phaseDone) begin nextState = ST_STOPC; strb.phaseClr = 1'b1; end
      ST_STOPC: if (phaseDone) begin nextState = ST_STOPD; strb.phaseClr = 1'b1; end
      ST_STOPD: if (phaseDone) begin nextState = ST_IDLE; strb.phaseClr = 1'b1; end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy  = (state != ST_IDLE);
  assign sclOe = (state == ST_LOW) || (state == ST_STOPA) || (state == ST_STOPB);
  assign sdaOe = (state == ST_STOPB) || (state == ST_STOPC);

  // R12
  sda_fall_in_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> (sclOe && $past(sclOe)));
  // R12
  sda_rise_in_scl_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> (!sclOe && !$past(sclOe)));
  // R5
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));
endmodule

// File: rtl/bus_clear_engine.sv
module bus_clear_engine
  import bc_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe
);
  dpStrobe_t strb;
  logic busy, termSet, startReq, phaseDone, lastPulse, actMode, actStop;
  logic [THR_W-1:0] actThr;

  bc_regs #(.ADDR_W(ADDR_W), .DATA_W(32)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .rdData(regRdData), .busy(busy), .termSet(termSet), .termSda(sdaIn),
    .startReq(startReq), .actThr(actThr), .actMode(actMode), .actStop(actStop));

  bc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .phaseDone(phaseDone),
    .lastPulse(lastPulse), .actMode(actMode), .actStop(actStop), .sdaIn(sdaIn),
    .strb(strb), .busy(busy), .termSet(termSet), .sclOe(sclOe), .sdaOe(sdaOe));

  bc_dpath #(.HALF_CYCLES(HALF_CYCLES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .actThr(actThr),
    .phaseDone(phaseDone), .lastPulse(lastPulse));
endmodule

// File: tb/bus_clear_engine_tb.sv
`timescale 1ns/1ps
module bus_clear_engine_tb;
  localparam int HALF = 4;
  localparam logic [7:0] CFG = 8'h84, STAT = 8'h88, LOAD = 8'h8C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = CFG;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic sclOe, sdaOe, sdaIn, sclLine, tgtLow;

  int vecs = 0;
  int errs = 0;
  int falls = 0;
  int base = 0;
  int hold = 0;
  int expQ[$];

  always #2.5 clk = ~clk;

  bus_clear_engine #(.HALF_CYCLES(HALF), .ADDR_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe));

  // target model: holds SDA low until more than `hold` SCL falls since op start
  assign sclLine = ~sclOe;
  assign tgtLow  = ((falls - base) <= hold);
  assign sdaIn   = ~(sdaOe | tgtLow);
  always @(negedge sclLine) falls = falls + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pushN(input int code, input int n);
    for (int i = 0; i < n; i++) expQ.push_back(code);
  endtask

  // code = scl*4 + sda*2 + busy
  task automatic buildExp(input int thr, input int mode, input int stop, input int h,
                          output int nPulse);
    int thrEff;
    thrEff = (thr == 0) ? 1 : thr;
    nPulse = mode ? thrEff : (((h + 1) < thrEff) ? (h + 1) : thrEff);
    expQ.delete();
    for (int p = 0; p < nPulse; p++) begin
      pushN(5, HALF);
      pushN(1, HALF);
    end
    if (stop != 0) begin
      pushN(5, HALF); pushN(7, HALF); pushN(3, HALF); pushN(1, HALF);
    end
    pushN(0, 2);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = CFG;
  endtask

  task automatic readChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, regRdData, exp);
    regAddr = CFG;
  endtask

  task automatic loadCfg();
    @(negedge clk);
    regWrEn = 1'b1; regAddr = LOAD; regWrData = 32'h1;
    @(negedge clk);
    chk("R4 load bit set", {31'd0, regRdData[0]}, 32'd1);
    regWrEn = 1'b0;
    @(negedge clk);
    chk("R4 load bit drops", {31'd0, regRdData[0]}, 32'd0);
    regAddr = CFG;
  endtask

  task automatic runOp(input string req, input logic [31:0] cfgWord,
                       input int thr, input int mode, input int stop, input int h,
                       input int pokeAt, input logic [7:0] pokeAddr, input logic [31:0] pokeData);
    int nPulse;
    int code;
    buildExp(thr, mode, stop, h, nPulse);
    @(negedge clk);
    base = falls; hold = h;
    regWrEn = 1'b1; regAddr = CFG; regWrData = cfgWord | 32'h1;
    for (int k = 0; k < expQ.size(); k++) begin
      @(negedge clk);
      code = expQ[k];
      chk({req, " R6 scl"}, {31'd0, sclOe}, {31'd0, code[2]});
      chk({req, " R9 sda"}, {31'd0, sdaOe}, {31'd0, code[1]});
      if (regAddr == CFG)
        chk({req, " R5 enable"}, {31'd0, regRdData[0]}, {31'd0, code[0]});
      regWrEn = 1'b0; regAddr = CFG;
      if (k == pokeAt) begin
        regWrEn = 1'b1; regAddr = pokeAddr; regWrData = pokeData;
      end
    end
    regWrEn = 1'b0; regAddr = CFG;
    readChk({req, " R10 status"}, STAT, (nPulse > h) ? 32'd1 : 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readChk("R1 cfg reset", CFG, 32'h0009_0004);
    readChk("R1 status reset", STAT, 32'd0);
    readChk("R1 load reset", LOAD, 32'd0);
    chk("R1 lines released", {30'd0, sclOe, sdaOe}, 32'd0);
    // R2 unmapped offset
    readChk("R2 unmapped", 8'h80, 32'd0);
    // R8 R9 defaults: early exit, stop, limit 9
    runOp("R8 early exit", 32'h0009_0004, 9, 0, 1, 3, -1, CFG, 0);
    // R3 shadow readback, R7 full count
    writeReg(CFG, 32'h0005_0002);
    readChk("R3 shadow readback", CFG, 32'h0005_0002);
    loadCfg();
    runOp("R7 full count", 32'h0005_0002, 5, 1, 0, 2, -1, CFG, 0);
    runOp("R10 stuck", 32'h0005_0002, 5, 1, 0, 10, -1, CFG, 0);
    // R3 shadow write alone has no effect
    runOp("R3 no load", 32'h0003_0004, 5, 1, 0, 10, -1, CFG, 0);
    readChk("R3 shadow kept", CFG, 32'h0003_0004);
    loadCfg();
    runOp("R9 stop after limit", 32'h0003_0004, 3, 0, 1, 10, -1, CFG, 0);
    // R11 enable write while busy ignored
    runOp("R11 poke enable", 32'h0003_0004, 3, 0, 1, 1, 6, CFG, 32'h0003_0005);
    // R4 load during operation deferred
    runOp("R4 deferred load", 32'h0002_0002, 3, 0, 1, 10, 3, LOAD, 32'h1);
    readChk("R4 deferred done", LOAD, 32'd0);
    runOp("R4 after deferred", 32'h0002_0002, 2, 1, 0, 10, -1, CFG, 0);
    // R7 limit zero gives one pulse
    writeReg(CFG, 32'h0000_0002);
    loadCfg();
    runOp("R7 limit zero", 32'h0000_0002, 0, 1, 0, 5, -1, CFG, 0);
    // R8 SDA already free
    writeReg(CFG, 32'h0007_0000);
    loadCfg();
    runOp("R8 free at first", 32'h0007_0000, 7, 0, 0, 0, -1, CFG, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule